// File: doc/BRIEF.md
# Test-Access Instruction Register with Opcode Decoder

This block is the instruction path of a boundary-scan test port. It has an 8-bit instruction shift register, an active-instruction latch and an opcode decoder. A TAP controller outside the block supplies one-cycle state strobes: capture, shift and update for the instruction and data paths, test-logic-reset, and entry into run-test/idle. During an instruction scan the register sits between `tdi` and `tdo`. It first loads a fixed capture word that carries two live status flags, the in-system-programming mode flag and the security flag. It then shifts the word out least-significant bit first while the new opcode shifts in.

When the update strobe arrives, the shifted opcode becomes the active instruction. The decoder turns it into a one-hot data-register select and into three pin-mode controls: drive from the scan cells, clamp, and float all outputs. The block also contains the 1-bit bypass register and the two 32-bit identification registers, one fixed and one user-programmable. A vendor-specific opcode drives the active-low configuration-start output `cf_n` low for a parameterised number of clocks. The boundary-scan cells are outside the block, and their serial return enters on `bsr_tdo`.

Top module: `jtag_ir_ctrl`

## Requirements
- R1: On reset, and on any cycle with `st_tlr` high, the active instruction becomes the identification opcode 8'hFE. As a result `sel_idcode`=1, every other select and mode output is 0, and `cf_n` stays 1 unless a pulse is already running.
- R2: A capture-IR strobe loads the word {3'b000, isp_mode, secure, 3'b001} into the instruction shift register. Bit 4 is the ISP-mode flag and bit 3 is the security flag.
- R3: While `st_shift_ir` is high, `tdo` shows bit 0 of the instruction shift register, and each clock shifts `tdi` into bit 7. Bits therefore leave least-significant first.
- R4: The new opcode has no effect on the select or mode outputs until the clock edge that carries `st_update_ir`. From the next cycle on, the outputs follow the new opcode.
- R5: The opcodes decode as follows. 8'hFF selects bypass. 8'h01 selects the boundary chain with no mode. 8'h00 selects the boundary chain and raises `mode_extest`. 8'hFE selects `sel_idcode`. 8'hFD selects `sel_usercode`. 8'hEE selects bypass.
- R6: Any opcode not listed in R5 or R9 selects the bypass register, and all mode outputs stay 0.
- R7: The bypass register captures 0 on capture-DR. During shift-DR it passes `tdi` to `tdo` with one clock of delay.
- R8: With the fixed identification register selected, a DR scan shifts out the parameter `IDCODE_VAL` least-significant bit first. Bit 0 is always 1, and this is checked at elaboration. The default is 32'h05026093.
- R9: 8'hFA raises `mode_clamp` and 8'hFC raises `mode_highz`. Both select the bypass register, and at most one mode output is high at a time.
- R10: The user identification register reads 32'hFFFFFFFF after reset. A cycle with `usercode_load` high replaces its value with `usercode_value`. With 8'hFD active, a DR scan shifts this value out least-significant bit first.
- R11: `cf_n` goes low for exactly `CF_LOW_CYCLES` clocks. The pulse starts in the cycle after an update-IR that loads 8'hEE, or after a `st_rti_entry` strobe while 8'hEE is already active. `st_rti_entry` has no effect under any other instruction.
- R12: With the boundary chain selected, `tdo` follows `bsr_tdo` during shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| st_capture_ir | input | 1 | Capture-IR state strobe |
| st_shift_ir | input | 1 | Shift-IR state strobe |
| st_update_ir | input | 1 | Update-IR state strobe |
| st_capture_dr | input | 1 | Capture-DR state strobe |
| st_shift_dr | input | 1 | Shift-DR state strobe |
| st_tlr | input | 1 | Test-logic-reset state strobe |
| st_rti_entry | input | 1 | One-cycle strobe on entry to run-test/idle |
| isp_mode | input | 1 | Live in-system-programming mode flag |
| secure | input | 1 | Live security-option flag |
| usercode_load | input | 1 | Writes `usercode_value` into the user register |
| usercode_value | input | 32 | Value written at programming time |
| bsr_tdo | input | 1 | Serial return of the external boundary chain |
| tdo | output | 1 | Serial data out |
| sel_bypass | output | 1 | Bypass register selected |
| sel_bscan | output | 1 | Boundary chain selected |
| sel_idcode | output | 1 | Fixed identification register selected |
| sel_usercode | output | 1 | User identification register selected |
| mode_extest | output | 1 | Pins are driven from the scan cells |
| mode_clamp | output | 1 | Pins are held at the scan-cell values while bypass is selected |
| mode_highz | output | 1 | All outputs float together |
| cf_n | output | 1 | Active-low configuration-start pulse |

## Verification
The hardest case to reach is the claim that a new opcode stays inert through the whole scan. Each of the 256 opcodes is shifted in, and before the update strobe the bench confirms that the outputs still reflect the previous instruction. It then checks the decoded outputs one cycle after the update. The same sweep varies the two status flags, so every scan also checks the capture word read back on `tdo`. The configuration pulse is reached in two ways: by loading its opcode, and by a run-test/idle entry while that opcode is already active. The bench also applies a run-test/idle entry under another opcode and confirms that no pulse follows.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;
   localparam int IR_W = 8;

   localparam logic [IR_W-1:0] OP_EXTEST   = 8'h00;
   localparam logic [IR_W-1:0] OP_SAMPLE   = 8'h01;
   localparam logic [IR_W-1:0] OP_CFG      = 8'hEE;
   localparam logic [IR_W-1:0] OP_CLAMP    = 8'hFA;
   localparam logic [IR_W-1:0] OP_HIGHZ    = 8'hFC;
   localparam logic [IR_W-1:0] OP_USERCODE = 8'hFD;
   localparam logic [IR_W-1:0] OP_IDCODE   = 8'hFE;
   localparam logic [IR_W-1:0] OP_BYPASS   = 8'hFF;

   typedef enum logic [1:0] {
      DR_BYPASS = 2'd0,
      DR_BSCAN  = 2'd1,
      DR_ID     = 2'd2,
      DR_USER   = 2'd3
   } dr_sel_e;

   typedef struct packed {
      dr_sel_e dr;
      logic    extest;
      logic    clamp;
      logic    highz;
      logic    cfg;
   } ir_dec_t;
endpackage

// File: rtl/jtag_ir_shift.sv
module jtag_ir_shift
   import jtag_ir_pkg::*;
#(
   parameter int W = IR_W,
   parameter logic [W-1:0] RESET_OP = OP_IDCODE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tdi,
   input  logic         capture,
   input  logic         shift,
   input  logic         update,
   input  logic         tlr,
   input  logic [W-1:0] cap_word,
   output logic [W-1:0] sh_q,
   output logic [W-1:0] active_q,
   output logic         so
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (capture) begin
         sh_q <= cap_word;
      end else if (shift) begin
         sh_q <= {tdi, sh_q[W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= RESET_OP;
      end else if (tlr) begin
         active_q <= RESET_OP;
      end else if (update) begin
         active_q <= sh_q;
      end
   end

   assign so = sh_q[0];
endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
   import jtag_ir_pkg::*;
(
   input  logic [IR_W-1:0] op,
   output ir_dec_t         dec
);
   always_comb begin
      dec        = '0;
      dec.dr     = DR_BYPASS;
      case (op)
         OP_EXTEST: begin
            dec.dr     = DR_BSCAN;
            dec.extest = 1'b1;
         end
         OP_SAMPLE:   dec.dr = DR_BSCAN;
         OP_IDCODE:   dec.dr = DR_ID;
         OP_USERCODE: dec.dr = DR_USER;
         OP_CLAMP:    dec.clamp = 1'b1;
         OP_HIGHZ:    dec.highz = 1'b1;
         OP_CFG:      dec.cfg = 1'b1;
         default:     dec.dr = DR_BYPASS;
      endcase
   end
endmodule

// File: rtl/jtag_cap_dr.sv
module jtag_cap_dr #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tdi,
   input  logic         capture,
   input  logic         shift,
   input  logic [W-1:0] cap_val,
   output logic         so
);
   logic [W-1:0] q;

   generate
      if (W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (capture) q <= cap_val;
            else if (shift)   q <= tdi;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (capture) q <= cap_val;
            else if (shift)   q <= {tdi, q[W-1:1]};
         end
      end
   endgenerate

   assign so = q[0];
endmodule

// File: rtl/jtag_cf_pulse.sv
module jtag_cf_pulse #(
   parameter int LOW_CYCLES = 4,
   localparam int CNT_W = $clog2(LOW_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic cf_n
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= CNT_W'(LOW_CYCLES);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign cf_n = (cnt == '0);
endmodule

// File: rtl/jtag_ir_ctrl.sv
module jtag_ir_ctrl
   import jtag_ir_pkg::*;
#(
   parameter int          ID_W          = 32,
   parameter logic [31:0] IDCODE_VAL    = 32'h05026093,
   parameter int          CF_LOW_CYCLES = 4,
   parameter int          ISP_BIT       = 4,
   parameter int          SEC_BIT       = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tdi,
   input  logic        st_capture_ir,
   input  logic        st_shift_ir,
   input  logic        st_update_ir,
   input  logic        st_capture_dr,
   input  logic        st_shift_dr,
   input  logic        st_tlr,
   input  logic        st_rti_entry,
   input  logic        isp_mode,
   input  logic        secure,
   input  logic        usercode_load,
   input  logic [31:0] usercode_value,
   input  logic        bsr_tdo,
   output logic        tdo,
   output logic        sel_bypass,
   output logic        sel_bscan,
   output logic        sel_idcode,
   output logic        sel_usercode,
   output logic        mode_extest,
   output logic        mode_clamp,
   output logic        mode_highz,
   output logic        cf_n
);
   localparam logic [IR_W-1:0] CAP_BASE = IR_W'(8'b0000_0001);

   // elaboration checks
   if (ID_W != 32) begin : g_bad_idw
      $error("ID_W must be 32");
   end
   if (IDCODE_VAL[0] != 1'b1) begin : g_bad_id
      $error("IDCODE_VAL bit 0 must be 1");
   end
   if (CF_LOW_CYCLES < 1) begin : g_bad_cf
      $error("CF_LOW_CYCLES must be at least 1");
   end
   if (ISP_BIT >= IR_W || SEC_BIT >= IR_W || ISP_BIT == SEC_BIT || ISP_BIT < 2 || SEC_BIT < 2) begin : g_bad_bits
      $error("status bit positions invalid");
   end

   logic [IR_W-1:0] cap_word;
   logic [IR_W-1:0] ir_sh;
   logic [IR_W-1:0] active_ir;
   logic            ir_so;
   ir_dec_t         dec;
   logic [ID_W-1:0] user_q;
   logic            cap_byp, cap_id, cap_user;
   logic            sh_byp, sh_id, sh_user;
   logic            byp_so, id_so, user_so;
   logic            cf_start;

   always_comb begin
      cap_word          = CAP_BASE;
      cap_word[ISP_BIT] = isp_mode;
      cap_word[SEC_BIT] = secure;
   end

   jtag_ir_shift #(.W(IR_W), .RESET_OP(OP_IDCODE)) u_ir (
      .clk      (clk),
      .rst_n    (rst_n),
      .tdi      (tdi),
      .capture  (st_capture_ir & ~st_tlr),
      .shift    (st_shift_ir & ~st_tlr),
      .update   (st_update_ir),
      .tlr      (st_tlr),
      .cap_word (cap_word),
      .sh_q     (ir_sh),
      .active_q (active_ir),
      .so       (ir_so)
   );

   jtag_ir_decode u_dec (
      .op  (active_ir),
      .dec (dec)
   );

   assign sel_bypass   = (dec.dr == DR_BYPASS);
   assign sel_bscan    = (dec.dr == DR_BSCAN);
   assign sel_idcode   = (dec.dr == DR_ID);
   assign sel_usercode = (dec.dr == DR_USER);
   assign mode_extest  = dec.extest;
   assign mode_clamp   = dec.clamp;
   assign mode_highz   = dec.highz;

   // user identification storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             user_q <= '1;
      else if (usercode_load) user_q <= usercode_value;
   end

   assign cap_byp  = st_capture_dr & sel_bypass;
   assign cap_id   = st_capture_dr & sel_idcode;
   assign cap_user = st_capture_dr & sel_usercode;
   assign sh_byp   = st_shift_dr & sel_bypass;
   assign sh_id    = st_shift_dr & sel_idcode;
   assign sh_user  = st_shift_dr & sel_usercode;

   jtag_cap_dr #(.W(1)) u_byp (
      .clk (clk), .rst_n (rst_n), .tdi (tdi),
      .capture (cap_byp), .shift (sh_byp),
      .cap_val (1'b0), .so (byp_so)
   );

   jtag_cap_dr #(.W(ID_W)) u_id (
      .clk (clk), .rst_n (rst_n), .tdi (tdi),
      .capture (cap_id), .shift (sh_id),
      .cap_val (IDCODE_VAL), .so (id_so)
   );

   jtag_cap_dr #(.W(ID_W)) u_user (
      .clk (clk), .rst_n (rst_n), .tdi (tdi),
      .capture (cap_user), .shift (sh_user),
      .cap_val (user_q), .so (user_so)
   );

   always_comb begin
      if (st_shift_ir) begin
         tdo = ir_so;
      end else begin
         case (dec.dr)
            DR_BSCAN: tdo = bsr_tdo;
            DR_ID:    tdo = id_so;
            DR_USER:  tdo = user_so;
            default:  tdo = byp_so;
         endcase
      end
   end

   assign cf_start = ~st_tlr &
                     ((st_update_ir & (ir_sh == OP_CFG)) |
                      (st_rti_entry & dec.cfg));

   jtag_cf_pulse #(.LOW_CYCLES(CF_LOW_CYCLES)) u_cf (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cf_start),
      .cf_n  (cf_n)
   );
endmodule

// File: rtl/jtag_ir_ctrl_chk.sv
module jtag_ir_ctrl_chk #(
   parameter int IR_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            st_capture_ir,
   input logic            st_update_ir,
   input logic            st_tlr,
   input logic            isp_mode,
   input logic            secure,
   input logic [IR_W-1:0] ir_sh,
   input logic [IR_W-1:0] active_ir,
   input logic            sel_bypass,
   input logic            sel_bscan,
   input logic            sel_idcode,
   input logic            sel_usercode,
   input logic            mode_extest,
   input logic            mode_clamp,
   input logic            mode_highz,
   input logic            cf_n
);
   // R1
   a_r1_tlr_to_id: assert property (@(posedge clk) disable iff (!rst_n)
      st_tlr |=> (sel_idcode && active_ir == 8'hFE));

   // R2
   a_r2_capture_word: assert property (@(posedge clk) disable iff (!rst_n)
      (st_capture_ir && !st_tlr) |=>
         (ir_sh == {3'b000, $past(isp_mode), $past(secure), 3'b001}));

   // R4
   a_r4_hold_until_update: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_update_ir && !st_tlr) |=> $stable(active_ir));

   // R5
   a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({sel_bypass, sel_bscan, sel_idcode, sel_usercode}) == 1);

   // R9
   a_r9_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mode_extest, mode_clamp, mode_highz}));

   a_r9_float_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_highz || mode_clamp) |-> sel_bypass);

   // R11
   a_r11_cf_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st_update_ir && !st_tlr && ir_sh == 8'hEE) |=> !cf_n);
endmodule

bind jtag_ir_ctrl jtag_ir_ctrl_chk #(.IR_W(8)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .st_capture_ir (st_capture_ir),
   .st_update_ir  (st_update_ir),
   .st_tlr        (st_tlr),
   .isp_mode      (isp_mode),
   .secure        (secure),
   .ir_sh         (ir_sh),
   .active_ir     (active_ir),
   .sel_bypass    (sel_bypass),
   .sel_bscan     (sel_bscan),
   .sel_idcode    (sel_idcode),
   .sel_usercode  (sel_usercode),
   .mode_extest   (mode_extest),
   .mode_clamp    (mode_clamp),
   .mode_highz    (mode_highz),
   .cf_n          (cf_n)
);

// File: tb/jtag_ir_ctrl_tb.sv
module jtag_ir_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CF_N = 3;
   localparam logic [31:0] ID_EXP = 32'h05026093;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tdi = 1'b0;
   logic st_capture_ir = 0, st_shift_ir = 0, st_update_ir = 0;
   logic st_capture_dr = 0, st_shift_dr = 0, st_tlr = 0, st_rti_entry = 0;
   logic isp_mode = 0, secure = 0, usercode_load = 0, bsr_tdo = 0;
   logic [31:0] usercode_value = '0;
   logic tdo, sel_bypass, sel_bscan, sel_idcode, sel_usercode;
   logic mode_extest, mode_clamp, mode_highz, cf_n;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jtag_ir_ctrl #(.CF_LOW_CYCLES(CF_N)) u_dut (
      .clk, .rst_n, .tdi, .st_capture_ir, .st_shift_ir, .st_update_ir,
      .st_capture_dr, .st_shift_dr, .st_tlr, .st_rti_entry, .isp_mode,
      .secure, .usercode_load, .usercode_value, .bsr_tdo, .tdo,
      .sel_bypass, .sel_bscan, .sel_idcode, .sel_usercode,
      .mode_extest, .mode_clamp, .mode_highz, .cf_n
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // {bypass, bscan, id, user, extest, clamp, highz}
   function automatic logic [6:0] exp_outs(input logic [7:0] op);
      case (op)
         8'h00:   return 7'b0100_100;
         8'h01:   return 7'b0100_000;
         8'hFE:   return 7'b0010_000;
         8'hFD:   return 7'b0001_000;
         8'hFA:   return 7'b1000_010;
         8'hFC:   return 7'b1000_001;
         default: return 7'b1000_000;
      endcase
   endfunction

   function automatic logic [6:0] outs();
      return {sel_bypass, sel_bscan, sel_idcode, sel_usercode,
              mode_extest, mode_clamp, mode_highz};
   endfunction

   // instruction scan; returns captured word read from tdo
   task automatic ir_scan(input logic [7:0] op, output logic [7:0] cap);
      st_capture_ir = 1;
      @(posedge clk); @(negedge clk);
      st_capture_ir = 0;
      st_shift_ir = 1;
      for (int i = 0; i < 8; i++) begin
         tdi = op[i];
         #1 cap[i] = tdo;
         @(posedge clk); @(negedge clk);
      end
      st_shift_ir = 0;
   endtask

   task automatic ir_update();
      st_update_ir = 1;
      @(posedge clk); @(negedge clk);
      st_update_ir = 0;
   endtask

   task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
      dout = '0;
      st_capture_dr = 1;
      @(posedge clk); @(negedge clk);
      st_capture_dr = 0;
      st_shift_dr = 1;
      for (int i = 0; i < n; i++) begin
         tdi = din[i];
         #1 dout[i] = tdo;
         @(posedge clk); @(negedge clk);
      end
      st_shift_dr = 0;
   endtask

   task automatic count_low(output int n);
      n = 0;
      #1;
      while (!cf_n && n < 40) begin
         n++;
         @(negedge clk); #1;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0]  cap;
      logic [6:0]  prev;
      logic [31:0] d;
      int          n;

      repeat (3) @(negedge clk);
      #1;
      check("R1 reset selects", 32'(outs()), 32'(7'b0010_000));
      check("R1 reset cf_n", 32'(cf_n), 32'd1);
      rst_n = 1;
      @(negedge clk);

      // R8 fixed identification
      dr_scan(32, 32'h0, d);
      check("R8 idcode shift", d, ID_EXP);
      check("R8 idcode bit0", 32'(d[0]), 32'd1);

      // R10 user register blank, then loaded
      ir_scan(8'hFD, cap); ir_update();
      dr_scan(32, 32'h0, d);
      check("R10 blank usercode", d, 32'hFFFF_FFFF);
      usercode_value = 32'hA5C3_1E70;
      usercode_load = 1;
      @(negedge clk);
      usercode_load = 0;
      dr_scan(32, 32'h0, d);
      check("R10 loaded usercode", d, 32'hA5C3_1E70);

      // full opcode sweep: R2 R3 capture, R4 hold, R5 R6 R9 decode
      prev = outs();
      for (int op = 0; op < 256; op++) begin
         isp_mode = op[0] ^ op[3];
         secure   = op[1];
         ir_scan(8'(op), cap);
         check("R2 R3 capture word", 32'(cap), 32'({3'b000, isp_mode, secure, 3'b001}));
         #1 check("R4 hold before update", 32'(outs()), 32'(prev));
         ir_update();
         #1 check("R5 R6 R9 decode", 32'(outs()), 32'(exp_outs(8'(op))));
         prev = outs();
         repeat (CF_N + 1) @(negedge clk);
      end

      // R7 bypass
      ir_scan(8'hFF, cap); ir_update();
      dr_scan(8, 32'h0000_00B2, d);
      check("R7 bypass delay", d, {24'h0, 8'hB2 << 1});

      // R12 boundary chain passthrough
      ir_scan(8'h01, cap); ir_update();
      bsr_tdo = 1;
      st_shift_dr = 1;
      #1 check("R12 bscan tdo high", 32'(tdo), 32'd1);
      bsr_tdo = 0;
      #1 check("R12 bscan tdo low", 32'(tdo), 32'd0);
      st_shift_dr = 0;
      @(negedge clk);

      // R1 test-logic-reset
      ir_scan(8'hFD, cap); ir_update();
      st_tlr = 1;
      @(posedge clk); @(negedge clk);
      st_tlr = 0;
      #1 check("R1 tlr selects", 32'(outs()), 32'(7'b0010_000));

      // R11 configuration pulse
      ir_scan(8'hEE, cap); ir_update();
      count_low(n);
      check("R11 pulse on update", 32'(n), 32'(CF_N));
      repeat (2) @(negedge clk);
      st_rti_entry = 1;
      @(posedge clk); @(negedge clk);
      st_rti_entry = 0;
      count_low(n);
      check("R11 pulse on rti entry", 32'(n), 32'(CF_N));
      ir_scan(8'hFF, cap); ir_update();
      st_rti_entry = 1;
      @(posedge clk); @(negedge clk);
      st_rti_entry = 0;
      n = 0;
      for (int i = 0; i < CF_N + 2; i++) begin
         #1 if (!cf_n) n++;
         @(negedge clk);
      end
      check("R11 rti ignored under bypass", 32'(n), 32'd0);

      summary();
      $finish;
   end
endmodule